// File: doc/BRIEF.md
# Adjacent-Wire Coupling Cost Meter

This block sits beside a parallel bus and, on every accepted bus word, estimates how much coupling energy the change from the previous word caused between wires that run side by side. Each neighbouring wire pair is scored from its old and new two-bit value. A pair where one wire switches and the other holds scores 1. A pair whose wires swing in opposite directions scores 4. Every other combination scores 0. The scores of all pairs are added to a per-pair running figure and to a bus-wide running total.

The physical wire order is not assumed to match the logical bit order. A map input names, for each physical track, the logical bit that it carries. Costs are therefore measured on the layout being evaluated, so one stream of traffic can be scored against several candidate orderings. Words arrive on a valid/ready stream. The block accepts a word on any cycle when `clr` is low, so back-pressure happens only during a clear cycle. A sender that sees `in_ready` low must hold its word until `in_ready` returns high. A read index selects which pair's figure appears on `rd_cost`.

Top module: `xt_cost_monitor`

## Requirements
- R1: A pair in which exactly one wire changes value adds 1 to that pair's figure.
- R2: A pair that keeps its value, that moves 00 to 11 or 11 to 00, or whose wires otherwise switch together adds 0.
- R3: A pair that moves 01 to 10 or 10 to 01 adds 4. The pair value is {track p+1, track p}.
- R4: `total_cost` grows by the sum of all N-1 pair scores of an accepted word. The new value is visible in the cycle after the accepting edge.
- R5: The first word accepted after reset or after a clear only becomes the previous word and adds nothing.
- R6: While `clr` is high, `in_ready` is low and any offered word is dropped. In the cycle after `clr`, every figure reads 0 and the previous word is forgotten.
- R7: A cycle without an accepted word leaves every figure unchanged.
- R8: Each pair figure (ACC_W bits) and the total (TOT_W bits) saturate at all ones instead of wrapping.
- R9: Physical track p carries logical bit `perm_map[p*IW +: IW]`. Pair index k is the pair of tracks k and k+1.
- R10: `rd_cost` shows the figure of pair `rd_idx` combinationally. An index of N-1 or more reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Zero all figures and forget the previous word |
| in_valid | input | 1 | Bus word offered |
| in_ready | output | 1 | Word can be taken (low only during clear) |
| in_data | input | N | Bus word in logical bit order |
| perm_map | input | N*IW | Logical bit index for each physical track |
| rd_idx | input | PW | Pair selected for reading |
| rd_cost | output | ACC_W | Figure of the selected pair |
| total_cost | output | TOT_W | Running sum over all pairs |

## Verification
Pair and total figures register on the edge that accepts a word. The bench therefore drives inputs on a falling edge and samples on the next falling edge, exactly one edge later. `rd_cost` is a pure mux, so it is sampled a moment after `rd_idx` changes without waiting for any edge. The effect of a clear is sampled in the cycle right after the cycle in which `clr` was high. The effect of `in_ready` is sampled while `clr` is still high.

// File: rtl/xt_pkg.sv
package xt_pkg;
  localparam int COST_W = 3;
  typedef logic [COST_W-1:0] pair_cost_t;

  // Score of one neighbouring pair, given its old and new value {hi, lo}.
  function automatic pair_cost_t pair_cost(input logic [1:0] was, input logic [1:0] now);
    logic [1:0] flip;
    flip = was ^ now;
    if (flip == 2'b01 || flip == 2'b10) return pair_cost_t'(1);
    if (flip == 2'b11 && (was[0] != was[1])) return pair_cost_t'(4);
    return pair_cost_t'(0);
  endfunction
endpackage

// File: rtl/xt_perm.sv
module xt_perm #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    word_log,
  input  logic [N*IW-1:0] map,
  output logic [N-1:0]    word_phys
);
  for (genvar p = 0; p < N; p++) begin : g_track
    logic [IW-1:0] src;
    assign src = map[p*IW +: IW];
    always_comb begin
      word_phys[p] = 1'b0;
      for (int b = 0; b < N; b++) begin
        if (src == IW'(b)) word_phys[p] = word_log[b];
      end
    end
  end
endmodule

// File: rtl/xt_pair_cost.sv
module xt_pair_cost
  import xt_pkg::*;
#(
  parameter int N = 16,
  localparam int PAIRS = N - 1,
  localparam int SUM_W = $clog2(4 * PAIRS + 1)
) (
  input  logic [N-1:0]            old_w,
  input  logic [N-1:0]            new_w,
  output logic [PAIRS*COST_W-1:0] costs,
  output logic [SUM_W-1:0]        step
);
  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign costs[k*COST_W +: COST_W] =
      pair_cost({old_w[k+1], old_w[k]}, {new_w[k+1], new_w[k]});
  end

  always_comb begin
    step = '0;
    for (int k = 0; k < PAIRS; k++) begin
      step = step + SUM_W'(costs[k*COST_W +: COST_W]);
    end
  end
endmodule

// File: rtl/xt_accum.sv
module xt_accum
  import xt_pkg::*;
#(
  parameter int PAIRS = 15,
  parameter int ACC_W = 32,
  parameter int TOT_W = 40,
  parameter int SUM_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    add_en,
  input  logic [PAIRS*COST_W-1:0] costs,
  input  logic [SUM_W-1:0]        step,
  output logic [PAIRS*ACC_W-1:0]  acc_flat,
  output logic [TOT_W-1:0]        total
);
  for (genvar k = 0; k < PAIRS; k++) begin : g_acc
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   wide;
    assign wide = {1'b0, acc_q} + (ACC_W+1)'(costs[k*COST_W +: COST_W]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (clr)    acc_q <= '0;
      else if (add_en) acc_q <= wide[ACC_W] ? '1 : wide[ACC_W-1:0];
    end
    assign acc_flat[k*ACC_W +: ACC_W] = acc_q;
  end

  logic [TOT_W-1:0] tot_q;
  logic [TOT_W:0]   tot_wide;
  assign tot_wide = {1'b0, tot_q} + (TOT_W+1)'(step);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tot_q <= '0;
    else if (clr)    tot_q <= '0;
    else if (add_en) tot_q <= tot_wide[TOT_W] ? '1 : tot_wide[TOT_W-1:0];
  end
  assign total = tot_q;
endmodule

// File: rtl/xt_cost_monitor.sv
module xt_cost_monitor
  import xt_pkg::*;
#(
  parameter int N     = 16,
  parameter int ACC_W = 32,
  parameter int TOT_W = 40,
  localparam int IW    = (N > 1) ? $clog2(N) : 1,
  localparam int PAIRS = N - 1,
  localparam int PW    = (PAIRS > 1) ? $clog2(PAIRS + 1) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [N-1:0]     in_data,
  input  logic [N*IW-1:0]  perm_map,
  input  logic [PW-1:0]    rd_idx,
  output logic [ACC_W-1:0] rd_cost,
  output logic [TOT_W-1:0] total_cost
);
  localparam int SUM_W = $clog2(4 * PAIRS + 1);

  logic                    accept;
  logic [N-1:0]            phys;
  logic [N-1:0]            prev_q;
  logic                    have_prev_q;
  logic [PAIRS*COST_W-1:0] costs;
  logic [SUM_W-1:0]        step;
  logic [PAIRS*ACC_W-1:0]  acc_flat;

  assign in_ready = !clr;
  assign accept   = in_valid && in_ready;

  xt_perm #(.N(N)) u_perm (
    .word_log  (in_data),
    .map       (perm_map),
    .word_phys (phys)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (clr) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (accept) begin
      prev_q      <= phys;
      have_prev_q <= 1'b1;
    end
  end

  xt_pair_cost #(.N(N)) u_cost (
    .old_w (prev_q),
    .new_w (phys),
    .costs (costs),
    .step  (step)
  );

  xt_accum #(.PAIRS(PAIRS), .ACC_W(ACC_W), .TOT_W(TOT_W), .SUM_W(SUM_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .add_en   (accept && have_prev_q),
    .costs    (costs),
    .step     (step),
    .acc_flat (acc_flat),
    .total    (total_cost)
  );

  always_comb begin
    rd_cost = '0;
    for (int k = 0; k < PAIRS; k++) begin
      if (rd_idx == PW'(k)) rd_cost = acc_flat[k*ACC_W +: ACC_W];
    end
  end
endmodule

// File: rtl/xt_cost_monitor_chk.sv
module xt_cost_monitor_chk #(
  parameter int N     = 16,
  parameter int ACC_W = 32,
  parameter int TOT_W = 40,
  localparam int PAIRS = N - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             in_valid,
  input logic             in_ready,
  input logic [ACC_W-1:0] rd_cost,
  input logic [TOT_W-1:0] total_cost
);
  logic acc_ok;
  logic armed_q;
  assign acc_ok = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (clr)    armed_q <= 1'b0;
    else if (acc_ok) armed_q <= 1'b1;
  end

  p_first_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !armed_q) |=> (total_cost == $past(total_cost)));

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (total_cost == '0 && rd_cost == '0));

  p_clear_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !in_ready);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_ok && !clr) |=> $stable(total_cost));

  p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && armed_q) |=> (total_cost >= $past(total_cost) &&
      (total_cost - $past(total_cost)) <= TOT_W'(4 * PAIRS)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (total_cost == {TOT_W{1'b1}} && !clr) |=> (total_cost == {TOT_W{1'b1}}));
endmodule

bind xt_cost_monitor xt_cost_monitor_chk #(.N(N), .ACC_W(ACC_W), .TOT_W(TOT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .rd_cost    (rd_cost),
  .total_cost (total_cost)
);

// File: tb/xt_cost_monitor_tb.sv
module xt_cost_monitor_tb;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int IW    = 3;
  localparam int PW    = 3;
  localparam int PAIRS = 7;
  localparam int ACC_W = 10;
  localparam int TOT_W = 12;
  localparam int NV    = 8;
  localparam logic [7:0]  VDATA [NV] = '{8'h00, 8'h01, 8'h02, 8'hFF, 8'h00, 8'h55, 8'hAA, 8'hAA};
  localparam logic [11:0] VTOT  [NV] = '{12'd0, 12'd1, 12'd6, 12'd8, 12'd8, 12'd15, 12'd43, 12'd43};

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, in_valid = 1'b0, in_ready;
  logic [N-1:0] in_data = '0;
  logic [N*IW-1:0] perm_map = '0;
  logic [PW-1:0] rd_idx = '0;
  logic [ACC_W-1:0] rd_cost;
  logic [TOT_W-1:0] total_cost;
  int n_total = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  xt_cost_monitor #(.N(N), .ACC_W(ACC_W), .TOT_W(TOT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .perm_map(perm_map), .rd_idx(rd_idx), .rd_cost(rd_cost),
    .total_cost(total_cost));

  task automatic chk(input string req, input longint act, input longint exp);
    n_total++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [N-1:0] w);
    @(negedge clk); in_data = w; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic do_clear(input logic [N-1:0] offered);
    @(negedge clk); clr = 1'b1; in_valid = 1'b1; in_data = offered;
    #1 chk("R6 ready low in clear", in_ready, 0);
    @(negedge clk); clr = 1'b0; in_valid = 1'b0;
    chk("R6 total zero after clear", total_cost, 0);
  endtask

  task automatic set_identity();
    for (int p = 0; p < N; p++) perm_map[p*IW +: IW] = IW'(p);
  endtask

  function automatic int mcost(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] f;
    f = a ^ b;
    if (f == 2'b01 || f == 2'b10) return 1;
    if (f == 2'b11 && a[0] != a[1]) return 4;
    return 0;
  endfunction

  function automatic logic [N-1:0] mperm(input logic [N-1:0] w, input logic [N*IW-1:0] m);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = w[m[p*IW +: IW]];
    return r;
  endfunction

  initial begin
    #(CLK_P * 100000);
    n_total++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    set_identity();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset total", total_cost, 0);
    chk("R10 reset pair read", rd_cost, 0);
    chk("R6 ready after reset", in_ready, 1);

    // Vector table: R1 R2 R3 R4 R5, identity order
    for (int v = 0; v < NV; v++) begin
      send(VDATA[v]);
      chk($sformatf("R4 vector %0d total", v), total_cost, VTOT[v]);
    end
    rd_idx = 3'd0; #1 chk("R3 pair0 figure", rd_cost, 11);
    rd_idx = 3'd1; #1 chk("R1 pair1 figure", rd_cost, 7);
    rd_idx = 3'd6; #1 chk("R2 pair6 figure", rd_cost, 5);
    rd_idx = 3'd7; #1 chk("R10 out of range read", rd_cost, 0);

    // R7: valid low with changing data
    @(negedge clk); in_data = 8'h55;
    @(negedge clk); in_data = 8'h0F;
    @(negedge clk);
    chk("R7 idle no change", total_cost, 43);

    // R6 + R5: word offered during clear is dropped, first word after free
    do_clear(8'h01);
    rd_idx = 3'd0; #1 chk("R6 pair zero after clear", rd_cost, 0);
    send(8'h02);
    chk("R5 first word after clear", total_cost, 0);
    send(8'h01);
    chk("R3 after clear 02->01", total_cost, 5);

    // R9: reversed track order, bit0 lands on track 7
    do_clear(8'h00);
    for (int p = 0; p < N; p++) perm_map[p*IW +: IW] = IW'(N - 1 - p);
    send(8'h00);
    send(8'h01);
    rd_idx = 3'd6; #1 chk("R9 reversed order pair6", rd_cost, 1);
    rd_idx = 3'd0; #1 chk("R9 reversed order pair0", rd_cost, 0);

    // R9 R4: random order and traffic against a model
    begin
      int macc [PAIRS];
      longint mtot;
      logic [N-1:0] mprev;
      logic mhave;
      int idx [N];
      do_clear(8'h00);
      for (int p = 0; p < N; p++) idx[p] = p;
      for (int p = N - 1; p > 0; p--) begin
        int j; int t;
        j = $urandom_range(p, 0);
        t = idx[p]; idx[p] = idx[j]; idx[j] = t;
      end
      for (int p = 0; p < N; p++) perm_map[p*IW +: IW] = IW'(idx[p]);
      for (int k = 0; k < PAIRS; k++) macc[k] = 0;
      mtot = 0; mhave = 1'b0; mprev = '0;
      for (int s = 0; s < 200; s++) begin
        logic [N-1:0] w; logic [N-1:0] ph;
        w = N'($urandom);
        if ($urandom_range(3, 0) == 0) begin
          @(negedge clk); in_data = w;
          @(negedge clk);
        end else begin
          send(w);
          ph = mperm(w, perm_map);
          if (mhave) begin
            for (int k = 0; k < PAIRS; k++) begin
              int c;
              c = mcost({mprev[k+1], mprev[k]}, {ph[k+1], ph[k]});
              macc[k] = (macc[k] + c > 1023) ? 1023 : macc[k] + c;
              mtot = (mtot + c > 4095) ? 4095 : mtot + c;
            end
          end
          mprev = ph; mhave = 1'b1;
        end
        if (s % 20 == 19) chk("R4 random total", total_cost, mtot);
      end
      for (int k = 0; k < PAIRS; k++) begin
        rd_idx = PW'(k); #1 chk($sformatf("R9 random pair %0d", k), rd_cost, macc[k]);
      end
    end

    // R8: saturation with alternating opposite swings
    do_clear(8'h00);
    set_identity();
    send(8'h55);
    for (int s = 0; s < 300; s++) send((s % 2 == 0) ? 8'hAA : 8'h55);
    rd_idx = 3'd3; #1 chk("R8 pair saturates", rd_cost, 1023);
    chk("R8 total saturates", total_cost, 4095);
    send(8'hAA);
    chk("R8 total holds at max", total_cost, 4095);

    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule